// File: doc/BRIEF.md
# Half-Cycle Bus Cycle Sequencer

This block produces the external bus activity of a small 8-bit processor, one machine cycle at a time. The clock it runs on is the half-cycle clock: every rising edge is one half of a processor clock period, so each phase length below is a count of half-cycles. The core hands over one request at a time, giving its cycle type, an address, write data, an extension code and, for an internal delay, a length. The sequencer then steps through named phases, drives the address, the strobes and the data out, and samples a wait input at the end of one phase in each cycle. It returns read data together with a one half-cycle completion pulse.

The phases are: `PH_IDLE` (waiting for a request), `PH_START` (4 half-cycles, address and strobes out), `PH_XTRA` (extra half-cycles in which wait is not sampled), `PH_SAMP` (2 half-cycles, wait sampled at its end), `PH_END` (2 half-cycles, data captured at its end), `PH_RFSH` (refresh after an opcode fetch), `PH_INTL` (internal delay with the bus quiet) and `PH_BACK` (2 half-cycle bus acknowledge phase). The transitions are as follows. `PH_IDLE` goes to `PH_BACK` on bus request, to `PH_INTL` on an internal request and to `PH_START` on any other request. `PH_START` goes to `PH_XTRA` for I/O cycles and for extended memory cycles, and to `PH_SAMP` otherwise. `PH_XTRA` always goes to `PH_SAMP`. `PH_SAMP` repeats while wait is high. If wait is low it goes to `PH_RFSH` after a fetch and to `PH_END` after anything else. `PH_END`, `PH_RFSH` and `PH_INTL` return to `PH_IDLE` and raise the completion pulse. `PH_BACK` repeats while bus request stays high and returns to `PH_IDLE` once it is low.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and after reset, with no request, all strobes, bus acknowledge and done are low, `addr_o` and `dout_o` are zero, and `req_ready` is high.
- R2: A memory read (`req_kind` 1) is 8 half-cycles long (4 start, 2 sampled, 2 end), with `mreq_o` and `rd_o` high and `addr_o` equal to the request address. `din` is captured into `rdata_o` on the final edge. Timing is measured from the edge that accepts the request: `done_o` is high in the half-cycle after the Nth edge that follows, where N is the cycle length.
- R3: A memory write (`req_kind` 2) has the same 8 half-cycle length, with `mreq_o` and `wr_o` high, `dout_o` equal to the write data, and `rd_o` never high together with `wr_o`.
- R4: For a memory read or write, `req_ext` code e adds 2·e half-cycles in which wait is not sampled, placed before the sampled phase (e=1 gives 10 half-cycles, e=2 gives 12).
- R5: An opcode fetch (`req_kind` 0) runs 4 start and 2 sampled half-cycles with `m1_o`, `mreq_o` and `rd_o` high, and captures the opcode at the end of the sampled phase. It then runs a refresh phase in which `rfsh_o` and `mreq_o` are high, `rd_o` and `m1_o` are low, and `addr_o` equals `rfsh_addr`.
- R6: The refresh length is set by `rfsh_cfg`: 0 gives 4 half-cycles, 1 gives 6, and 2 or 3 gives 8.
- R7: An I/O input (`req_kind` 3, `iorq_o` with `rd_o`) or output (`req_kind` 4, `iorq_o` with `wr_o`) runs 4 start, 2 automatic unsampled, 2 sampled and 2 end half-cycles, 10 in total. `req_ext` has no effect on I/O cycles or on fetches.
- R8: Each time `wait_req` is high at the end of the sampled phase, that 2 half-cycle phase is repeated.
- R9: An internal request (`req_kind` 5, 6 or 7) lasts `req_len` half-cycles (a length of 0 counts as 1), with every strobe low and `addr_o` zero.
- R10: While `bus_req` is high at the start or the end of a phase, the block issues 2 half-cycle acknowledge phases with `busack_o` high, holds `req_ready` low, accepts no request and drives no strobe.
- R11: `done_o` is high for exactly one half-cycle at the end of every cycle type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle type code |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_ext | input | XW | Memory cycle extension code |
| req_len | input | LW | Internal delay length in half-cycles |
| req_ready | output | 1 | Request accepted on this edge if valid |
| wait_req | input | 1 | Wait request, active high |
| bus_req | input | 1 | External bus request |
| rfsh_cfg | input | 2 | Refresh length select |
| rfsh_addr | input | AW | Address driven during refresh |
| din | input | DW | Read data from the bus |
| addr_o | output | AW | Address bus |
| dout_o | output | DW | Write data bus |
| mreq_o | output | 1 | Memory request strobe |
| iorq_o | output | 1 | I/O request strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| m1_o | output | 1 | Opcode fetch marker |
| rfsh_o | output | 1 | Refresh marker |
| busack_o | output | 1 | Bus acknowledge |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | Cycle complete pulse |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit data, a 2-bit extension code and a 5-bit internal length. With these, both extension codes used by real extended reads and writes can be exercised, and internal delays of 6, 8 and 10 half-cycles as well as the zero-length corner all fit the length field. All four refresh settings are reachable through `rfsh_cfg`, including the code 3 that aliases to 8. Wait stretches are placed on the first sampling edge of reads, fetches and I/O cycles, and are repeated twice on one read.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_XTRA,
        PH_SAMP,
        PH_END,
        PH_RFSH,
        PH_INTL,
        PH_BACK
    } phase_e;

    localparam logic [2:0] KD_FETCH = 3'd0;
    localparam logic [2:0] KD_MRD   = 3'd1;
    localparam logic [2:0] KD_MWR   = 3'd2;
    localparam logic [2:0] KD_IOIN  = 3'd3;
    localparam logic [2:0] KD_IOOUT = 3'd4;

    function automatic logic kind_is_io(input logic [2:0] k);
        return (k == KD_IOIN) || (k == KD_IOOUT);
    endfunction

    function automatic logic kind_is_mem(input logic [2:0] k);
        return (k == KD_MRD) || (k == KD_MWR);
    endfunction

    function automatic logic kind_is_intl(input logic [2:0] k);
        return k > KD_IOOUT;
    endfunction

    function automatic logic kind_reads(input logic [2:0] k);
        return (k == KD_FETCH) || (k == KD_MRD) || (k == KD_IOIN);
    endfunction

    function automatic logic kind_writes(input logic [2:0] k);
        return (k == KD_MWR) || (k == KD_IOOUT);
    endfunction

endpackage

// File: rtl/bus_phase_len.sv
module bus_phase_len
    import bus_seq_pkg::*;
#(
    parameter int LW = 5,
    parameter int XW = 2
) (
    input  phase_e          nxt,
    input  logic [2:0]      kind,
    input  logic [XW-1:0]   ext,
    input  logic [1:0]      rcfg,
    input  logic [LW-1:0]   ilen,
    output logic [LW-1:0]   load
);
    logic [LW-1:0] len;

    always_comb begin
        len = LW'(2);
        unique case (nxt)
            PH_IDLE:  len = LW'(1);
            PH_START: len = LW'(4);
            PH_XTRA:  len = kind_is_io(kind) ? LW'(2) : LW'({ext, 1'b0});
            PH_SAMP,
            PH_END,
            PH_BACK:  len = LW'(2);
            PH_RFSH: begin
                if (rcfg == 2'd0)      len = LW'(4);
                else if (rcfg == 2'd1) len = LW'(6);
                else                   len = LW'(8);
            end
            PH_INTL:  len = (ilen == '0) ? LW'(1) : ilen;
        endcase
        load = len - LW'(1);
    end

endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  phase_e          ph,
    input  logic [2:0]      kind,
    input  logic [AW-1:0]   addr_q,
    input  logic [AW-1:0]   rfsh_addr,
    input  logic [DW-1:0]   wdata_q,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   dout_o,
    output logic            mreq_o,
    output logic            iorq_o,
    output logic            rd_o,
    output logic            wr_o,
    output logic            m1_o,
    output logic            rfsh_o,
    output logic            busack_o
);
    always_comb begin
        addr_o   = '0;
        dout_o   = '0;
        mreq_o   = 1'b0;
        iorq_o   = 1'b0;
        rd_o     = 1'b0;
        wr_o     = 1'b0;
        m1_o     = 1'b0;
        rfsh_o   = 1'b0;
        busack_o = 1'b0;
        unique case (ph)
            PH_START, PH_XTRA, PH_SAMP, PH_END: begin
                addr_o = addr_q;
                mreq_o = kind_is_mem(kind) || (kind == KD_FETCH);
                iorq_o = kind_is_io(kind);
                rd_o   = kind_reads(kind);
                wr_o   = kind_writes(kind);
                m1_o   = (kind == KD_FETCH);
                if (kind_writes(kind)) dout_o = wdata_q;
            end
            PH_RFSH: begin
                addr_o = rfsh_addr;
                mreq_o = 1'b1;
                rfsh_o = 1'b1;
            end
            PH_BACK: busack_o = 1'b1;
            PH_IDLE, PH_INTL: begin
            end
        endcase
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int XW = 2,
    parameter int LW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [XW-1:0]   req_ext,
    input  logic [LW-1:0]   req_len,
    output logic            req_ready,
    input  logic            wait_req,
    input  logic            bus_req,
    input  logic [1:0]      rfsh_cfg,
    input  logic [AW-1:0]   rfsh_addr,
    input  logic [DW-1:0]   din,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   dout_o,
    output logic            mreq_o,
    output logic            iorq_o,
    output logic            rd_o,
    output logic            wr_o,
    output logic            m1_o,
    output logic            rfsh_o,
    output logic            busack_o,
    output logic [DW-1:0]   rdata_o,
    output logic            done_o
);
    phase_e          state_q, nxt;
    logic [LW-1:0]   left_q, load;
    logic [2:0]      kind_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic [XW-1:0]   ext_q;
    logic [DW-1:0]   rdata_q;
    logic            done_q;
    logic            step, accept, capture;

    assign step      = (left_q == '0);
    assign req_ready = (state_q == PH_IDLE) && !bus_req;
    assign accept    = req_ready && req_valid;
    assign capture   = step &&
                       (((state_q == PH_END) && kind_reads(kind_q)) ||
                        ((state_q == PH_SAMP) && (kind_q == KD_FETCH) && !wait_req));

    // next phase, taken only when the current phase ends
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (bus_req)        nxt = PH_BACK;
                else if (req_valid) nxt = kind_is_intl(req_kind) ? PH_INTL : PH_START;
            end
            PH_START: begin
                if (kind_is_io(kind_q) || (kind_is_mem(kind_q) && (ext_q != '0)))
                    nxt = PH_XTRA;
                else
                    nxt = PH_SAMP;
            end
            PH_XTRA: nxt = PH_SAMP;
            PH_SAMP: begin
                if (wait_req)                nxt = PH_SAMP;
                else if (kind_q == KD_FETCH) nxt = PH_RFSH;
                else                         nxt = PH_END;
            end
            PH_END, PH_RFSH, PH_INTL: nxt = PH_IDLE;
            PH_BACK: nxt = bus_req ? PH_BACK : PH_IDLE;
        endcase
    end

    bus_phase_len #(.LW(LW), .XW(XW)) u_len (
        .nxt  (nxt),
        .kind (kind_q),
        .ext  (ext_q),
        .rcfg (rfsh_cfg),
        .ilen (req_len),
        .load (load)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            left_q  <= '0;
            kind_q  <= KD_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            ext_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (step) begin
                state_q <= nxt;
                left_q  <= load;
            end else begin
                left_q  <= left_q - LW'(1);
            end
            if (accept) begin
                kind_q  <= req_kind;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                ext_q   <= req_ext;
            end
            if (capture) rdata_q <= din;
            done_q <= step && ((state_q == PH_END) || (state_q == PH_RFSH) ||
                               (state_q == PH_INTL));
        end
    end

    // outputs
    bus_strobe_dec #(.AW(AW), .DW(DW)) u_dec (
        .ph        (state_q),
        .kind      (kind_q),
        .addr_q    (addr_q),
        .rfsh_addr (rfsh_addr),
        .wdata_q   (wdata_q),
        .addr_o    (addr_o),
        .dout_o    (dout_o),
        .mreq_o    (mreq_o),
        .iorq_o    (iorq_o),
        .rd_o      (rd_o),
        .wr_o      (wr_o),
        .m1_o      (m1_o),
        .rfsh_o    (rfsh_o),
        .busack_o  (busack_o)
    );

    assign rdata_o = rdata_q;
    assign done_o  = done_q;

    assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o));

    assert_rfsh_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_o) |-> $past(m1_o));

    assert_ack_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busack_o |-> !(mreq_o || iorq_o || rd_o || wr_o));

    assert_ack_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busack_o |-> !req_ready);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_bus_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(rd_o || wr_o || busack_o));

endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [1:0]  req_ext = '0;
    logic [4:0]  req_len = '0;
    logic        req_ready;
    logic        wait_req = 1'b0;
    logic        bus_req = 1'b0;
    logic [1:0]  rfsh_cfg = '0;
    logic [15:0] rfsh_addr = 16'h3F12;
    logic [7:0]  din = '0;
    logic [15:0] addr_o;
    logic [7:0]  dout_o, rdata_o;
    logic        mreq_o, iorq_o, rd_o, wr_o, m1_o, rfsh_o, busack_o, done_o;

    int total = 0;
    int bad = 0;

    // strobe vector bit order: {rfsh, m1, iorq, mreq, wr, rd}
    localparam logic [5:0] S_FETCH = 6'b110101;
    localparam logic [5:0] S_MRD   = 6'b000101;
    localparam logic [5:0] S_MWR   = 6'b000110;
    localparam logic [5:0] S_IOIN  = 6'b001001;
    localparam logic [5:0] S_IOOUT = 6'b001010;

    always #5 clk = ~clk;

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ext(req_ext),
        .req_len(req_len), .req_ready(req_ready), .wait_req(wait_req),
        .bus_req(bus_req), .rfsh_cfg(rfsh_cfg), .rfsh_addr(rfsh_addr), .din(din),
        .addr_o(addr_o), .dout_o(dout_o), .mreq_o(mreq_o), .iorq_o(iorq_o),
        .rd_o(rd_o), .wr_o(wr_o), .m1_o(m1_o), .rfsh_o(rfsh_o),
        .busack_o(busack_o), .rdata_o(rdata_o), .done_o(done_o)
    );

    task automatic check(input string tag, input logic ok, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [2:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input logic [1:0] e, input logic [4:0] ln,
                          input int rel_n, input int exp_n, input logic [5:0] exp_strb,
                          input logic chk_rd, input logic [7:0] exp_rd);
        int n;
        logic [5:0] seen;
        logic bus_ok;
        logic got;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        req_ext = e; req_len = ln; wait_req = (rel_n > 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; seen = '0; bus_ok = 1'b1; got = 1'b0;
        while (n < 80 && !got) begin
            seen |= {rfsh_o, m1_o, iorq_o, mreq_o, wr_o, rd_o};
            if ((mreq_o || iorq_o) && !rfsh_o && addr_o != a) bus_ok = 1'b0;
            if (rfsh_o && addr_o != rfsh_addr) bus_ok = 1'b0;
            if (wr_o && dout_o != wd) bus_ok = 1'b0;
            if (!(mreq_o || iorq_o) && addr_o != 16'h0) bus_ok = 1'b0;
            if (rel_n > 0 && n == rel_n) wait_req = 1'b0;
            @(posedge clk);
            @(negedge clk);
            n++;
            if (done_o) got = 1'b1;
        end
        wait_req = 1'b0;
        check(tag, got && n == exp_n, "cycle length", n, exp_n);
        check(tag, seen == exp_strb, "strobes seen", int'(seen), int'(exp_strb));
        check(tag, bus_ok, "address/data bus", int'(bus_ok), 1);
        if (chk_rd) check(tag, rdata_o == exp_rd, "read data", rdata_o, exp_rd);
        @(posedge clk);
        @(negedge clk);
        check("R11", done_o == 1'b0, "done pulse width", done_o, 0);
    endtask

    task automatic test_reset;
        @(negedge clk);
        check("R1", {mreq_o, iorq_o, rd_o, wr_o, m1_o, rfsh_o, busack_o, done_o} == 8'h0,
              "strobes in reset", {mreq_o, iorq_o, rd_o, wr_o, m1_o, rfsh_o, busack_o, done_o}, 0);
        check("R1", addr_o == 16'h0 && dout_o == 8'h0, "buses in reset", addr_o, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", req_ready == 1'b1, "ready after reset", req_ready, 1);
        check("R1", {mreq_o, rd_o, wr_o, busack_o, done_o} == 5'h0, "idle strobes",
              {mreq_o, rd_o, wr_o, busack_o, done_o}, 0);
    endtask

    task automatic test_mem_read;
        din = 8'hA5;
        run_op("R2", 3'd1, 16'h1234, 8'h00, 2'd0, 5'd0, 0, 8, S_MRD, 1'b1, 8'hA5);
        din = 8'h3C;
        run_op("R2", 3'd1, 16'hFFFE, 8'h00, 2'd0, 5'd0, 0, 8, S_MRD, 1'b1, 8'h3C);
    endtask

    task automatic test_mem_write;
        run_op("R3", 3'd2, 16'h8001, 8'h5A, 2'd0, 5'd0, 0, 8, S_MWR, 1'b0, 8'h00);
    endtask

    task automatic test_extended;
        din = 8'h11;
        run_op("R4", 3'd1, 16'h0040, 8'h00, 2'd1, 5'd0, 0, 10, S_MRD, 1'b1, 8'h11);
        din = 8'h22;
        run_op("R4", 3'd1, 16'h0041, 8'h00, 2'd2, 5'd0, 0, 12, S_MRD, 1'b1, 8'h22);
        run_op("R4", 3'd2, 16'h0042, 8'hC3, 2'd2, 5'd0, 0, 12, S_MWR, 1'b0, 8'h00);
    endtask

    task automatic test_fetch;
        din = 8'h76;
        rfsh_cfg = 2'd0;
        run_op("R5", 3'd0, 16'h0100, 8'h00, 2'd0, 5'd0, 0, 10, S_FETCH, 1'b1, 8'h76);
        rfsh_cfg = 2'd1;
        run_op("R6", 3'd0, 16'h0101, 8'h00, 2'd0, 5'd0, 0, 12, S_FETCH, 1'b1, 8'h76);
        rfsh_cfg = 2'd2;
        run_op("R6", 3'd0, 16'h0102, 8'h00, 2'd0, 5'd0, 0, 14, S_FETCH, 1'b1, 8'h76);
        rfsh_cfg = 2'd3;
        run_op("R6", 3'd0, 16'h0103, 8'h00, 2'd0, 5'd0, 0, 14, S_FETCH, 1'b1, 8'h76);
        rfsh_cfg = 2'd0;
        run_op("R7", 3'd0, 16'h0104, 8'h00, 2'd2, 5'd0, 0, 10, S_FETCH, 1'b1, 8'h76);
    endtask

    task automatic test_io;
        din = 8'h9D;
        run_op("R7", 3'd3, 16'h00FE, 8'h00, 2'd0, 5'd0, 0, 10, S_IOIN, 1'b1, 8'h9D);
        run_op("R7", 3'd4, 16'h10FE, 8'h47, 2'd0, 5'd0, 0, 10, S_IOOUT, 1'b0, 8'h00);
        run_op("R7", 3'd4, 16'h20FE, 8'h48, 2'd2, 5'd0, 0, 10, S_IOOUT, 1'b0, 8'h00);
    endtask

    task automatic test_wait;
        din = 8'hE1;
        run_op("R8", 3'd1, 16'h4000, 8'h00, 2'd0, 5'd0, 6, 10, S_MRD, 1'b1, 8'hE1);
        run_op("R8", 3'd1, 16'h4001, 8'h00, 2'd0, 5'd0, 8, 12, S_MRD, 1'b1, 8'hE1);
        run_op("R8", 3'd0, 16'h4002, 8'h00, 2'd0, 5'd0, 6, 12, S_FETCH, 1'b1, 8'hE1);
        run_op("R8", 3'd3, 16'h4003, 8'h00, 2'd0, 5'd0, 8, 12, S_IOIN, 1'b1, 8'hE1);
    endtask

    task automatic test_internal;
        run_op("R9", 3'd5, 16'h7777, 8'h00, 2'd0, 5'd6, 0, 6, 6'b0, 1'b0, 8'h00);
        run_op("R9", 3'd6, 16'h7777, 8'h00, 2'd0, 5'd8, 0, 8, 6'b0, 1'b0, 8'h00);
        run_op("R9", 3'd7, 16'h7777, 8'h00, 2'd0, 5'd10, 0, 10, 6'b0, 1'b0, 8'h00);
        run_op("R9", 3'd5, 16'h7777, 8'h00, 2'd0, 5'd0, 0, 1, 6'b0, 1'b0, 8'h00);
    endtask

    task automatic test_bus_request;
        logic ack_ok;
        logic cleared;
        @(negedge clk);
        bus_req = 1'b1;
        req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h5555; req_ext = '0;
        @(posedge clk);
        @(negedge clk);
        check("R10", busack_o == 1'b1 && req_ready == 1'b0, "ack and ready", busack_o, 1);
        ack_ok = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (!busack_o || mreq_o || iorq_o || rd_o || wr_o || done_o || req_ready)
                ack_ok = 1'b0;
        end
        check("R10", ack_ok, "held acknowledge, no cycle", int'(ack_ok), 1);
        req_valid = 1'b0;
        bus_req = 1'b0;
        cleared = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (!cleared) begin
                @(posedge clk);
                @(negedge clk);
                if (!busack_o && req_ready) cleared = 1'b1;
            end
        end
        check("R10", cleared, "release of acknowledge", int'(cleared), 1);
        din = 8'h66;
        run_op("R10", 3'd1, 16'h5556, 8'h00, 2'd0, 5'd0, 0, 8, S_MRD, 1'b1, 8'h66);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_mem_read();
        test_mem_write();
        test_extended();
        test_fetch();
        test_io();
        test_wait();
        test_internal();
        test_bus_request();
        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule